// File: doc/BRIEF.md
# CAN Receive Rule Filter

This block sits after a CAN frame decoder. It takes one decoded frame at a time (identifier, extended-format flag, remote flag, length code and payload) on a single-cycle strobe. It compares the frame against a bank of programmable receive rules and files the frame into one of several small receive queues. A host drains each queue through a pop port.

Every rule holds an identifier, an extended flag and a remote flag, each with a bit mask. It also holds a minimum length code, a queue index and an enable bit. Rules are written through a configuration port. The rule scan visits one rule per clock, starting from rule 0 and moving upward. The first enabled rule that matches decides the fate of the frame. If that rule's length test fails, the frame is lost and no further rule is consulted. If its queue is full, the frame is also lost. Three saturating counters record frames that matched no rule, frames rejected on length, and frames refused by a full queue.

Top module: `can_rx_rule_filter`

## Requirements
- R1: After reset every rule is disabled. A disabled rule never matches, and a rule written with `cfg_en`=1 takes part in the scan.
- R2: An enabled rule matches when, for the identifier, the extended flag and the remote flag alike, `(frame XOR rule) AND mask` is zero. A mask bit of 1 makes that bit count, and a mask bit of 0 makes it a don't-care.
- R3: Rules are scanned in ascending index from 0. When several rules match, only the lowest-indexed one is used.
- R4: The length test runs only on the selected rule and passes when `frm_dlc >= min_dlc`, compared as unsigned 4-bit values, so a minimum of 0 always passes. On a failure the scan stops, nothing is stored and `cnt_dlc_drop` increments.
- R5: A frame that matches no enabled rule is not stored and increments `cnt_nomatch`.
- R6: A frame that passes both tests while its target queue is full is discarded, the queue contents stay unchanged, and `cnt_full_drop` increments.
- R7: `busy` rises in the cycle after an accepted strobe. The scan takes one cycle per rule visited, so a frame decided by rule r keeps `busy` high for r+1 cycles, and an unmatched frame keeps it high for NRULES cycles.
- R8: A strobe that arrives while `busy` is high is ignored and raises `overrun` for exactly one cycle, in the cycle after the strobe.
- R9: Each queue is first-in first-out. The read port shows the head of the queue chosen by `pop_sel`, and a `pop` on a non-empty queue removes that head.
- R10: Each queue reports empty, full (count equals DEPTH) and its message count, with queue f at `fifo_count[f*CW +: CW]`. A pop on an empty queue changes nothing.
- R11: Each drop counter saturates at 2^CNT_W-1.
- R12: A stored frame comes back on the read port with the identifier, flags, length code and payload unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write the rule chosen by `cfg_idx` |
| cfg_idx | input | RIW | Rule index |
| cfg_en | input | 1 | Rule enable |
| cfg_id | input | 29 | Rule identifier |
| cfg_id_mask | input | 29 | Identifier compare mask |
| cfg_ide | input | 1 | Rule extended flag |
| cfg_ide_mask | input | 1 | Extended flag compare mask |
| cfg_rtr | input | 1 | Rule remote flag |
| cfg_rtr_mask | input | 1 | Remote flag compare mask |
| cfg_min_dlc | input | 4 | Minimum length code |
| cfg_fifo | input | FIW | Target queue index |
| frm_valid | input | 1 | Frame strobe, one cycle |
| frm_id | input | 29 | Frame identifier |
| frm_ide | input | 1 | Frame extended flag |
| frm_rtr | input | 1 | Frame remote flag |
| frm_dlc | input | 4 | Frame length code |
| frm_data | input | DATA_W | Frame payload |
| busy | output | 1 | Rule scan in progress |
| overrun | output | 1 | One-cycle flag for an ignored strobe |
| pop | input | 1 | Remove the head of the selected queue |
| pop_sel | input | FIW | Queue selected for read and pop |
| rd_id | output | 29 | Head identifier |
| rd_ide | output | 1 | Head extended flag |
| rd_rtr | output | 1 | Head remote flag |
| rd_dlc | output | 4 | Head length code |
| rd_data | output | DATA_W | Head payload |
| fifo_empty | output | NFIFO | Per-queue empty |
| fifo_full | output | NFIFO | Per-queue full |
| fifo_count | output | NFIFO*CW | Per-queue message counts |
| cnt_nomatch | output | CNT_W | Frames that matched no rule |
| cnt_dlc_drop | output | CNT_W | Frames rejected on length |
| cnt_full_drop | output | CNT_W | Frames refused by a full queue |

## Verification
Matching is exercised with three kinds of frame. An exact identifier hit on a mid-bank rule shows that masked bits are compared. A hit that differs only in a masked-off identifier bit shows that unmasked bits are ignored. Frames that differ in identifier or remote flag fall through to a catch-all rule, and the length of the `busy` window tells which rule index decided. A frame that matches two rules shows that the lower index wins. A short frame on a rule with a length minimum, sent while a later catch-all rule exists, separates "stop at the first match" from "keep scanning". Filling a queue past its depth, sending a strobe during a scan, and running unmatched frames past the counter limit cover the full-queue, overrun and saturation paths.

// File: rtl/can_rx_rule_filter.sv
module can_rx_rule_filter #(
  parameter int NRULES = 8,
  parameter int NFIFO  = 2,
  parameter int DEPTH  = 4,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 8,
  localparam int RIW = (NRULES > 1) ? $clog2(NRULES) : 1,
  localparam int FIW = (NFIFO > 1) ? $clog2(NFIFO) : 1,
  localparam int CW  = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [RIW-1:0]        cfg_idx,
  input  logic                  cfg_en,
  input  logic [28:0]           cfg_id,
  input  logic [28:0]           cfg_id_mask,
  input  logic                  cfg_ide,
  input  logic                  cfg_ide_mask,
  input  logic                  cfg_rtr,
  input  logic                  cfg_rtr_mask,
  input  logic [3:0]            cfg_min_dlc,
  input  logic [FIW-1:0]        cfg_fifo,
  input  logic                  frm_valid,
  input  logic [28:0]           frm_id,
  input  logic                  frm_ide,
  input  logic                  frm_rtr,
  input  logic [3:0]            frm_dlc,
  input  logic [DATA_W-1:0]     frm_data,
  output logic                  busy,
  output logic                  overrun,
  input  logic                  pop,
  input  logic [FIW-1:0]        pop_sel,
  output logic [28:0]           rd_id,
  output logic                  rd_ide,
  output logic                  rd_rtr,
  output logic [3:0]            rd_dlc,
  output logic [DATA_W-1:0]     rd_data,
  output logic [NFIFO-1:0]      fifo_empty,
  output logic [NFIFO-1:0]      fifo_full,
  output logic [NFIFO*CW-1:0]   fifo_count,
  output logic [CNT_W-1:0]      cnt_nomatch,
  output logic [CNT_W-1:0]      cnt_dlc_drop,
  output logic [CNT_W-1:0]      cnt_full_drop
);
  localparam int EW = 29 + 1 + 1 + 4 + DATA_W;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic           r_en   [NRULES];
  logic [28:0]    r_id   [NRULES];
  logic [28:0]    r_idm  [NRULES];
  logic           r_ide  [NRULES];
  logic           r_idem [NRULES];
  logic           r_rtr  [NRULES];
  logic           r_rtrm [NRULES];
  logic [3:0]     r_mdlc [NRULES];
  logic [FIW-1:0] r_fifo [NRULES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NRULES; i++) begin
        r_en[i]   <= 1'b0;
        r_id[i]   <= '0;
        r_idm[i]  <= '0;
        r_ide[i]  <= 1'b0;
        r_idem[i] <= 1'b0;
        r_rtr[i]  <= 1'b0;
        r_rtrm[i] <= 1'b0;
        r_mdlc[i] <= '0;
        r_fifo[i] <= '0;
      end
    end else if (cfg_we) begin
      r_en[cfg_idx]   <= cfg_en;
      r_id[cfg_idx]   <= cfg_id;
      r_idm[cfg_idx]  <= cfg_id_mask;
      r_ide[cfg_idx]  <= cfg_ide;
      r_idem[cfg_idx] <= cfg_ide_mask;
      r_rtr[cfg_idx]  <= cfg_rtr;
      r_rtrm[cfg_idx] <= cfg_rtr_mask;
      r_mdlc[cfg_idx] <= cfg_min_dlc;
      r_fifo[cfg_idx] <= cfg_fifo;
    end
  end

  logic [28:0]       f_id;
  logic              f_ide, f_rtr;
  logic [3:0]        f_dlc;
  logic [DATA_W-1:0] f_data;
  logic [RIW-1:0]    idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx    <= '0;
      f_id   <= '0;
      f_ide  <= 1'b0;
      f_rtr  <= 1'b0;
      f_dlc  <= '0;
      f_data <= '0;
    end else if (!busy) begin
      if (frm_valid) begin
        busy   <= 1'b1;
        idx    <= '0;
        f_id   <= frm_id;
        f_ide  <= frm_ide;
        f_rtr  <= frm_rtr;
        f_dlc  <= frm_dlc;
        f_data <= frm_data;
      end
    end else if (hit || last) begin
      busy <= 1'b0;
    end else begin
      idx <= idx + RIW'(1);
    end
  end

  logic           hit, dlc_ok, last, tgt_ok, tgt_full, push;
  logic [FIW-1:0] tgt;

  assign hit = r_en[idx]
             && (((f_id  ^ r_id[idx])  & r_idm[idx])  == '0)
             && (((f_ide ^ r_ide[idx]) & r_idem[idx]) == 1'b0)
             && (((f_rtr ^ r_rtr[idx]) & r_rtrm[idx]) == 1'b0);
  assign dlc_ok   = f_dlc >= r_mdlc[idx];
  assign last     = idx == RIW'(NRULES - 1);
  assign tgt      = r_fifo[idx];
  assign tgt_ok   = 32'(tgt) < NFIFO;
  assign tgt_full = tgt_ok ? fifo_full[tgt] : 1'b1;
  assign push     = busy && hit && dlc_ok && !tgt_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overrun       <= 1'b0;
      cnt_nomatch   <= '0;
      cnt_dlc_drop  <= '0;
      cnt_full_drop <= '0;
    end else begin
      overrun <= frm_valid && busy;
      if (busy && !hit && last && cnt_nomatch != '1)
        cnt_nomatch <= cnt_nomatch + CNT_W'(1);
      if (busy && hit && !dlc_ok && cnt_dlc_drop != '1)
        cnt_dlc_drop <= cnt_dlc_drop + CNT_W'(1);
      if (busy && hit && dlc_ok && tgt_full && cnt_full_drop != '1)
        cnt_full_drop <= cnt_full_drop + CNT_W'(1);
    end
  end

  logic [EW-1:0] entry;
  logic [EW-1:0] heads [NFIFO];
  assign entry = {f_id, f_ide, f_rtr, f_dlc, f_data};

  for (genvar g = 0; g < NFIFO; g++) begin : g_fifo
    logic [EW-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          psh, pp;

    assign psh = push && tgt == FIW'(g);
    assign pp  = pop && pop_sel == FIW'(g) && cnt != '0;

    always_ff @(posedge clk) if (psh) mem[wp] <= entry;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (psh) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
        if (pp)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
        cnt <= cnt + CW'(psh) - CW'(pp);
      end
    end

    assign heads[g]                = mem[rp];
    assign fifo_empty[g]           = cnt == '0;
    assign fifo_full[g]            = cnt == CW'(DEPTH);
    assign fifo_count[g*CW +: CW]  = cnt;

    a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
    a_r10_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && pop && pop_sel == FIW'(g) && fifo_empty[g]) |=> fifo_empty[g]);
    a_r6_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_full[g] && !(pop && pop_sel == FIW'(g))) |=> fifo_full[g]);
  end

  assign {rd_id, rd_ide, rd_rtr, rd_dlc, rd_data} = heads[pop_sel];

  a_r7_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !busy) |=> busy);
  a_r8_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && busy) |=> overrun);
  a_r4_dlc_ends_scan: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hit && !dlc_ok) |=> !busy);
  a_r11_nomatch_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_nomatch == '1) |=> (cnt_nomatch == '1));
  a_r11_full_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_full_drop == '1) |=> (cnt_full_drop == '1));
endmodule

// File: tb/can_rx_rule_filter_test.sv
module can_rx_rule_filter_test;
  localparam int CW = 3;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic        cfg_we = 0, cfg_en = 0, cfg_ide = 0, cfg_ide_mask = 0, cfg_rtr = 0, cfg_rtr_mask = 0;
  logic [2:0]  cfg_idx = 0;
  logic [28:0] cfg_id = 0, cfg_id_mask = 0;
  logic [3:0]  cfg_min_dlc = 0;
  logic        cfg_fifo = 0;
  logic        frm_valid = 0, frm_ide = 0, frm_rtr = 0;
  logic [28:0] frm_id = 0;
  logic [3:0]  frm_dlc = 0;
  logic [63:0] frm_data = 0;
  logic        busy, overrun, pop = 0, pop_sel = 0;
  logic [28:0] rd_id;
  logic        rd_ide, rd_rtr;
  logic [3:0]  rd_dlc;
  logic [63:0] rd_data;
  logic [1:0]  fifo_empty, fifo_full;
  logic [5:0]  fifo_count;
  logic [7:0]  cnt_nomatch, cnt_dlc_drop, cnt_full_drop;

  can_rx_rule_filter uut (.*);

  int n_chk = 0, n_bad = 0, cyc = 0, bcyc = 0;

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] cnt_of(int f);
    return fifo_count[f*CW +: CW];
  endfunction

  task automatic rule(int i, bit en, logic [28:0] id, logic [28:0] idm, bit ide, bit idem,
                      bit rtr, bit rtrm, logic [3:0] mdlc, bit fifo);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 3'(i); cfg_en = en; cfg_id = id; cfg_id_mask = idm;
    cfg_ide = ide; cfg_ide_mask = idem; cfg_rtr = rtr; cfg_rtr_mask = rtrm;
    cfg_min_dlc = mdlc; cfg_fifo = fifo;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send(logic [28:0] id, bit ide, bit rtr, logic [3:0] dlc, logic [63:0] d);
    @(negedge clk);
    frm_valid = 1; frm_id = id; frm_ide = ide; frm_rtr = rtr; frm_dlc = dlc; frm_data = d;
    @(negedge clk);
    frm_valid = 0;
    bcyc = 0;
    while (busy && bcyc < 100) begin
      bcyc++;
      @(negedge clk);
    end
  endtask

  task automatic pop_check(bit f, string req, logic [28:0] id, bit ide, bit rtr,
                           logic [3:0] dlc, logic [63:0] d);
    @(negedge clk);
    pop_sel = f;
    #1;
    check(req, {rd_id, rd_ide, rd_rtr, rd_dlc}, {id, ide, rtr, dlc});
    check(req, rd_data, d);
    pop = 1;
    @(negedge clk);
    pop = 0;
  endtask

  task automatic t_reset;
    check("R10 reset empty", fifo_empty, 2'b11);
    check("R10 reset full", fifo_full, 2'b00);
    check("R10 reset count", fifo_count, 0);
    check("R7 reset busy", busy, 0);
    check("R11 reset counters", {cnt_nomatch, cnt_dlc_drop, cnt_full_drop}, 0);
    send(29'h10, 0, 0, 4'd8, 64'h1);
    check("R1 disabled rules give no match", cnt_nomatch, 1);
    check("R7 unmatched busy length", bcyc, 8);
    check("R1 nothing stored", fifo_count, 0);
  endtask

  task automatic t_match;
    rule(2, 1, 29'h123, 29'h7FF, 0, 1, 0, 1, 0, 0);
    rule(5, 1, 29'h0, 29'h0, 0, 0, 0, 0, 0, 1);
    send(29'h123, 0, 0, 4'd2, 64'hA1);
    check("R7 busy for rule 2", bcyc, 3);
    send(29'h124, 0, 0, 4'd3, 64'hB2);
    check("R3 falls to rule 5", bcyc, 6);
    send(29'h123, 0, 1, 4'd1, 64'hC3);
    check("R2 remote flag compared", bcyc, 6);
    send(29'h1123, 1'b0, 0, 4'd7, 64'hD4);
    check("R2 masked-off id bit ignored", bcyc, 3);
    check("R10 count fifo0", cnt_of(0), 2);
    check("R10 count fifo1", cnt_of(1), 2);
    pop_check(0, "R12 R9 fifo0 first", 29'h123, 0, 0, 4'd2, 64'hA1);
    pop_check(0, "R9 fifo0 second", 29'h1123, 0, 0, 4'd7, 64'hD4);
    pop_check(1, "R9 fifo1 first", 29'h124, 0, 0, 4'd3, 64'hB2);
    pop_check(1, "R12 fifo1 second", 29'h123, 0, 1, 4'd1, 64'hC3);
    @(negedge clk); pop_sel = 1; pop = 1;
    @(negedge clk); pop = 0;
    check("R10 pop on empty", {fifo_empty, fifo_count}, {2'b11, 6'd0});
  endtask

  task automatic t_priority;
    rule(1, 1, 29'h55, 29'h1FFFFFFF, 0, 1, 0, 1, 0, 1);
    rule(3, 1, 29'h55, 29'h1FFFFFFF, 0, 1, 0, 1, 0, 0);
    send(29'h55, 0, 0, 4'd4, 64'h55);
    check("R3 lowest rule wins", {cnt_of(1), cnt_of(0)}, {3'd1, 3'd0});
    check("R7 busy for rule 1", bcyc, 2);
    pop_check(1, "R3 popped", 29'h55, 0, 0, 4'd4, 64'h55);
  endtask

  task automatic t_dlc;
    rule(0, 1, 29'h77, 29'h1FFFFFFF, 0, 1, 0, 1, 4'd5, 0);
    send(29'h77, 0, 0, 4'd4, 64'h44);
    check("R4 short frame dropped, no later rule", fifo_count, 0);
    check("R4 dlc counter", cnt_dlc_drop, 1);
    check("R4 scan stopped at rule 0", bcyc, 1);
    send(29'h77, 0, 0, 4'd5, 64'h45);
    send(29'h77, 0, 0, 4'd8, 64'h48);
    check("R4 equal and longer pass", cnt_of(0), 2);
    pop_check(0, "R4 stored", 29'h77, 0, 0, 4'd5, 64'h45);
    pop_check(0, "R4 stored", 29'h77, 0, 0, 4'd8, 64'h48);
  endtask

  task automatic t_full;
    for (int i = 0; i < 5; i++) send(29'h77, 0, 0, 4'd8, 64'(100 + i));
    check("R6 queue full", {fifo_full[0], cnt_of(0)}, {1'b1, 3'd4});
    check("R6 full counter", cnt_full_drop, 1);
    for (int i = 0; i < 4; i++)
      pop_check(0, "R6 contents unchanged", 29'h77, 0, 0, 4'd8, 64'(100 + i));
    check("R10 empty after drain", fifo_empty[0], 1);
  endtask

  task automatic t_overrun;
    @(negedge clk);
    frm_valid = 1; frm_id = 29'h300; frm_dlc = 4'd1; frm_data = 64'hAA;
    @(negedge clk);
    frm_data = 64'hBB;
    @(negedge clk);
    frm_valid = 0;
    check("R8 overrun pulse", overrun, 1);
    @(negedge clk);
    check("R8 overrun one cycle", overrun, 0);
    while (busy) @(negedge clk);
    check("R8 only first frame stored", cnt_of(1), 1);
    pop_check(1, "R8 first frame kept", 29'h300, 0, 0, 4'd1, 64'hAA);
  endtask

  task automatic t_sat;
    rule(5, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 300; i++) send(29'h600, 0, 0, 4'd0, 64'(i));
    check("R11 nomatch saturates", cnt_nomatch, 8'hFF);
    check("R5 nothing stored", fifo_count, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 100000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_match();
    t_priority();
    t_dlc();
    t_full();
    t_overrun();
    t_sat();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule